// File: doc/BRIEF.md
# I2C Bit-Timing Enable Generator

This block paces an I2C master from a single system clock without creating any derived clock. A free-running divider counts from zero up to a terminal value and then wraps. An internal SCL phase flips each time the divider passes zero, so one SCL half-period lasts one full divider cycle. From the divider and the phase, the block decodes four single-cycle strobes in the system clock domain:

- an SCL rising strobe;
- an SCL falling strobe;
- a mid-low strobe, where the controller may change SDA;
- a mid-high strobe, where the controller samples SDA.

The SCL output follows the internal phase only while the controller asks for clocking. Otherwise it stays released high, which the controller uses in idle and around start, repeated-start and stop conditions. The raw SDA pad value passes through a two-flop synchronizer. The mid-high strobe captures the synchronized value into a held sample output. The byte-level protocol controller sits outside this block and consumes the strobes as clock enables.

Top module: `i2c_bit_pacer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it releases, `scl_o` is 1, all four strobes are 0 and `sda_smp` is 1.
- R2: The internal SCL phase holds each level for exactly TERM_CNT+1 cycles (39 with the default TERM_CNT of 38), so a full SCL period lasts 2*(TERM_CNT+1) cycles. The first phase after reset is low.
- R3: `fall_en` is high for exactly one cycle, on the first cycle of each low phase. `rise_en` is high for exactly one cycle, on the first cycle of each high phase.
- R4: `drive_en` is high for exactly one cycle per low phase, TERM_CNT/2 cycles after that phase's `fall_en`. It is never high while the internal phase is high.
- R5: `sample_en` is high for exactly one cycle per high phase, TERM_CNT/2 cycles after that phase's `rise_en`. It is never high while the internal phase is low.
- R6: When `scl_run` is 1, `scl_o` equals the internal phase. When `scl_run` is 0, `scl_o` is 1. `scl_run` has no effect on the strobes or on the phase timing.
- R7: On the cycle after a `sample_en` pulse, `sda_smp` shows the `sda_pad` value that was stable for at least two cycles before that pulse. At all other times `sda_smp` holds its value, even when `sda_pad` changes.
- R8: At most one of `rise_en`, `fall_en`, `drive_en` and `sample_en` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| scl_run | input | 1 | 1 lets SCL toggle; 0 holds SCL released high |
| sda_pad | input | 1 | Raw SDA level read back from the pad |
| scl_o | output | 1 | SCL level (1 = released) |
| rise_en | output | 1 | Strobe on the first cycle of an SCL high phase |
| fall_en | output | 1 | Strobe on the first cycle of an SCL low phase |
| drive_en | output | 1 | Mid-low strobe: SDA may change |
| sample_en | output | 1 | Mid-high strobe: SDA is captured |
| sda_smp | output | 1 | Synchronized SDA value held since the last capture |

## Verification
Every cycle across several SCL periods, the bench compares each strobe and `scl_o` against a position computed from the cycle count alone. A shifted or missing strobe, or a wrong divider length, therefore shows up as a cycle mismatch rather than a count mismatch. `scl_run` is toggled at points that are not aligned to the divider. This separates a gate that only masks the output from one that disturbs the timing. SDA is driven with an alternating pattern at each change point and flipped again during the high phase after each capture. This separates correct capture-and-hold from a sample that tracks the pad or picks up the wrong edge.

// File: rtl/i2c_tick_pkg.sv
package i2c_tick_pkg;

  typedef struct packed {
    logic rise;
    logic fall;
    logic drive;
    logic sample;
  } tick_t;

  localparam int TICK_W = 4;

endpackage

// File: rtl/scl_div_core.sv
module scl_div_core #(
  parameter int TERM_CNT = 38
) (
  input  logic                         clk,
  input  logic                         rst_n,
  output logic [$clog2(TERM_CNT+1)-1:0] cnt_o,
  output logic                         phase_o
);

  localparam int CW = $clog2(TERM_CNT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic          wrap;

  assign wrap = (cnt_q == CW'(TERM_CNT));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    ph_d  = ph_q;
    if (cnt_q == '0) ph_d = ~ph_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign phase_o = ph_q;

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(TERM_CNT));

  // R2
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(TERM_CNT)) |=> (cnt_q == '0));

endmodule

// File: rtl/tick_decode.sv
module tick_decode
  import i2c_tick_pkg::*;
#(
  parameter int TERM_CNT = 38,
  parameter int MID_CNT  = TERM_CNT / 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(TERM_CNT+1)-1:0] cnt,
  input  logic                          phase,
  output tick_t                         tick_o
);

  localparam int CW = $clog2(TERM_CNT + 1);

  tick_t tick_q, tick_d;
  logic  at_zero, at_mid;

  assign at_zero = (cnt == '0);
  assign at_mid  = (cnt == CW'(MID_CNT));

  always_comb begin
    tick_d.rise   = at_zero & ~phase;
    tick_d.fall   = at_zero &  phase;
    tick_d.drive  = at_mid  & ~phase;
    tick_d.sample = at_mid  &  phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign tick_o = tick_q;

  // R4
  drive_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q.drive |-> !phase);

  // R5
  sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q.sample |-> phase);

  // R3
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q.fall |=> !tick_q.fall);

  // R3
  rise_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q.rise |-> phase);

endmodule

// File: rtl/sda_capture.sv
module sda_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pad_i,
  input  logic cap_en,
  output logic smp_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   smp_q, smp_d;

  generate
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[0] <= 1'b1;
          else        sync_q[0] <= pad_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[g] <= 1'b1;
          else        sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_comb begin
    smp_d = smp_q;
    if (cap_en) smp_d = sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= 1'b1;
    else        smp_q <= smp_d;
  end

  assign smp_o = smp_q;

  // R7
  smp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(smp_q));

endmodule

// File: rtl/i2c_bit_pacer.sv
module i2c_bit_pacer
  import i2c_tick_pkg::*;
#(
  parameter int TERM_CNT    = 38,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_run,
  input  logic sda_pad,
  output logic scl_o,
  output logic rise_en,
  output logic fall_en,
  output logic drive_en,
  output logic sample_en,
  output logic sda_smp
);

  localparam int CW      = $clog2(TERM_CNT + 1);
  localparam int MID_CNT = TERM_CNT / 2;

  logic [CW-1:0] cnt;
  logic          phase;
  tick_t         tick;

  scl_div_core #(.TERM_CNT(TERM_CNT)) i_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_o   (cnt),
    .phase_o (phase)
  );

  tick_decode #(.TERM_CNT(TERM_CNT), .MID_CNT(MID_CNT)) i_dec (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (cnt),
    .phase  (phase),
    .tick_o (tick)
  );

  sda_capture #(.SYNC_STAGES(SYNC_STAGES)) i_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_i  (sda_pad),
    .cap_en (tick.sample),
    .smp_o  (sda_smp)
  );

  assign scl_o     = scl_run ? phase : 1'b1;
  assign rise_en   = tick.rise;
  assign fall_en   = tick.fall;
  assign drive_en  = tick.drive;
  assign sample_en = tick.sample;

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_en, fall_en, drive_en, sample_en}));

  // R6
  drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_en && scl_run) |-> !scl_o);

endmodule

// File: tb/test_i2c_bit_pacer.sv
module test_i2c_bit_pacer;

  localparam int TERM = 38;
  localparam int HALF = TERM + 1;
  localparam int MID  = TERM / 2;
  localparam int RUN  = 12 * HALF;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_run;
  logic sda_pad;
  logic scl_o, rise_en, fall_en, drive_en, sample_en, sda_smp;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  i2c_bit_pacer #(.TERM_CNT(TERM), .SYNC_STAGES(2)) i_i2c_bit_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_run   (scl_run),
    .sda_pad   (sda_pad),
    .scl_o     (scl_o),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .drive_en  (drive_en),
    .sample_en (sample_en),
    .sda_smp   (sda_smp)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int cyc);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic exp_smp;
    logic last_drv;
    logic ph;
    logic pend;
    int   last_rise;
    int   last_fall;
    int   drv_seen;
    int   smp_seen;

    rst_n     = 1'b0;
    scl_run   = 1'b0;
    sda_pad   = 1'b1;
    exp_smp   = 1'b1;
    last_drv  = 1'b1;
    pend      = 1'b0;
    last_rise = -1;
    last_fall = -1;
    drv_seen  = 0;
    smp_seen  = 0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    chk("R1", scl_o, 1'b1, -1);
    chk("R1", rise_en | fall_en | drive_en | sample_en, 1'b0, -1);
    chk("R1", sda_smp, 1'b1, -1);
    scl_run = 1'b1;
    sda_pad = 1'b0;
    #1;
    chk("R1", scl_o, 1'b1, -1);

    @(negedge clk);
    rst_n = 1'b1;

    for (int k = 1; k <= RUN; k++) begin
      @(posedge clk);
      #2;
      begin
        int j, pos, t;
        logic e_r, e_f, e_d, e_s;
        j   = k - 1;
        pos = j % HALF;
        t   = j / HALF + 1;
        ph  = ((t % 2) == 0);
        e_f = (pos == 0)   && (t % 2 == 1);
        e_r = (pos == 0)   && (t % 2 == 0);
        e_d = (pos == MID) && (t % 2 == 1);
        e_s = (pos == MID) && (t % 2 == 0);
        if (k == 1) chk("R1", rise_en | drive_en | sample_en, 1'b0, k);
        chk("R3", fall_en, e_f, k);
        chk("R3", rise_en, e_r, k);
        chk("R4", drive_en, e_d, k);
        chk("R5", sample_en, e_s, k);
        chk("R8", $countones({rise_en, fall_en, drive_en, sample_en}) <= 1, 1'b1, k);
        chk("R6", scl_o, scl_run ? ph : 1'b1, k);
        if (pend) begin
          exp_smp = last_drv;
          pend    = 1'b0;
        end
        chk("R7", sda_smp, exp_smp, k);

        // R2: half-period spacing between opposite edges
        if (fall_en) begin
          if (last_rise >= 0) chk_int("R2 rise-to-fall", k - last_rise, HALF);
          last_fall = k;
        end
        if (rise_en) begin
          if (last_fall >= 0) chk_int("R2 fall-to-rise", k - last_fall, HALF);
          last_rise = k;
        end
        if (drive_en) begin
          drv_seen++;
          chk_int("R4 offset", k - last_fall, MID);
          last_drv = (drv_seen % 2 == 1) ? 1'b1 : 1'b0;
          sda_pad  = last_drv;
        end
        if (sample_en) begin
          smp_seen++;
          chk_int("R5 offset", k - last_rise, MID);
          pend = 1'b1;
        end
        // R7: disturb pad during high phase after the capture
        if (ph && pos == MID + 5) sda_pad = ~last_drv;
        // R6: gate toggles at points unaligned to the divider
        if (k % 53 == 0) scl_run = ~scl_run;
      end
    end

    chk_int("R4 count", drv_seen, 6);
    chk_int("R5 count", smp_seen, 6);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule